// File: doc/BRIEF.md
# Interrupt Priority Level Arbiter

This block turns pending interrupt requests into a single priority level and decides whether the processor should take an interrupt. Two sources feed it. The first is a software request register that is loaded through a masked write port. The second is a vector of external request lines sampled every cycle. Software request bits map to levels offset from their bit position. External lines map straight onto a band of levels placed above every software level. The highest active level across both sources wins.

The winning level is compared with a 5-bit current priority level register every cycle. When the level is nonzero and strictly above the current level, and the trap controller has armed the block, a registered one-cycle take pulse is produced. On the same edge, two status registers are loaded. The summary register receives a bitmask of every active request at its own bit position. The interrupt-ID register receives the winning level. Software has no write path to the interrupt-ID register.

Top module: `ipl_arb`

## Requirements
- R1: After reset, `take` is 0 and `summary_q`, `intid_q`, `sw_req_q` and `ipl_q` are all zero.
- R2: A write to the software request register stores only bits 4 through 18 of `sw_wdata` (mask 0x7fff0). All other bits of `sw_req_q` read back as 0, and a write of only those other bits leaves no request pending.
- R3: An active software request bit i (4 to 18) gives level i minus 3, so software levels run from 1 to 15.
- R4: An active external line j (0 to 7) gives level 20 plus j. Any active external line outranks every software request, and among active requests the highest level wins.
- R5: An interrupt is taken only when the winning level is nonzero and strictly greater than `ipl_q`. A winning level equal to `ipl_q` is not taken.
- R6: `take` rises on the clock edge after the conditions of R5 hold with `arm` high. It stays high for exactly one cycle, even if `arm` remains high.
- R7: On the edge that raises `take`, two registers are loaded. `summary_q` receives the software requests at bits 4 to 18 ORed with external line j at bit 20 plus j. `intid_q` receives the winning level.
- R8: While `take` is low, `summary_q` and `intid_q` keep their values.
- R9: With `arm` low, no interrupt is taken, whatever the requests and `ipl_q` are.
- R10: `ipl_q` is loaded from `ipl_wdata` when `ipl_wr` is high and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Write strobe for the software request register |
| sw_wdata | input | DATA_W | Write data for the software request register (masked) |
| ipl_wr | input | 1 | Write strobe for the current priority level register |
| ipl_wdata | input | 5 | New current priority level |
| ext_irq | input | EXT_N | External request lines, one level each |
| arm | input | 1 | Enable from the trap controller; cleared while a trap is in progress |
| take | output | 1 | One-cycle request to take the interrupt |
| sw_req_q | output | DATA_W | Software request register readback |
| ipl_q | output | 5 | Current priority level register |
| summary_q | output | DATA_W | Captured request summary bitmask |
| intid_q | output | 5 | Captured winning level (read-only) |

## Verification
The hardest case to reach from the ports is the boundary where the winning level exactly equals the current priority level. That boundary is only meaningful when it appears at both the top of the software band and the top of the external band. It also needs a prior capture, so that the held status is distinguishable from reset values. The stimulus therefore first takes an interrupt at a known level. It then writes the priority register to equal the next request's level and arms the block. It checks that `take` stays low and that the earlier summary and ID survive. Each scenario leaves `arm` high for a second cycle so that the single-cycle pulse shape is observed rather than assumed.

// File: rtl/ipl_arb_pkg.sv
package ipl_arb_pkg;

   localparam int LVL_W = 5;

   // contiguous field of n ones starting at bit lo
   function automatic logic [63:0] field_mask(int lo, int n);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < 64; i++) begin
         if (i >= lo && i < lo + n) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/ipl_swreq_reg.sv
module ipl_swreq_reg #(
   parameter int DATA_W = 32,
   parameter int SW_LO  = 4,
   parameter int SW_N   = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   localparam logic [DATA_W-1:0] WMASK = DATA_W'(ipl_arb_pkg::field_mask(SW_LO, SW_N));

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (wr) q <= wdata & WMASK;
   end
endmodule

// File: rtl/ipl_prio_enc.sv
module ipl_prio_enc #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          any
);
   // upward scan: the last active bit seen is the highest and wins
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i]) begin
            idx = IW'(i);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/ipl_arb.sv
module ipl_arb
   import ipl_arb_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int SW_LO    = 4,
   parameter int SW_N     = 15,
   parameter int EXT_BASE = 20,
   parameter int EXT_N    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr,
   input  logic [DATA_W-1:0] sw_wdata,
   input  logic              ipl_wr,
   input  logic [LVL_W-1:0]  ipl_wdata,
   input  logic [EXT_N-1:0]  ext_irq,
   input  logic              arm,
   output logic              take,
   output logic [DATA_W-1:0] sw_req_q,
   output logic [LVL_W-1:0]  ipl_q,
   output logic [DATA_W-1:0] summary_q,
   output logic [LVL_W-1:0]  intid_q
);
   localparam int SW_IW  = $clog2(SW_N);
   localparam int EXT_IW = $clog2(EXT_N);
   localparam int EXT_TOP = EXT_BASE + EXT_N - 1;

   // elaboration-time parameter checks
   if (SW_N < 2 || EXT_N < 2) begin : g_bad_count
      $error("ipl_arb: SW_N and EXT_N must be at least 2");
   end
   if (EXT_BASE <= SW_N) begin : g_bad_band
      $error("ipl_arb: external band must sit above software levels");
   end
   if (EXT_TOP >= (1 << LVL_W)) begin : g_bad_lvl
      $error("ipl_arb: external levels exceed level width");
   end
   if (SW_LO + SW_N > DATA_W || EXT_TOP >= DATA_W) begin : g_bad_width
      $error("ipl_arb: request fields exceed DATA_W");
   end

   // state registers
   ipl_swreq_reg #(.DATA_W(DATA_W), .SW_LO(SW_LO), .SW_N(SW_N)) i_swreq (
      .clk(clk), .rst_n(rst_n), .wr(sw_wr), .wdata(sw_wdata), .q(sw_req_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      ipl_q <= '0;
      else if (ipl_wr) ipl_q <= ipl_wdata;
   end

   // per-source priority scan
   logic [SW_IW-1:0]  sw_idx;
   logic              sw_any;
   logic [EXT_IW-1:0] ext_idx;
   logic              ext_any;

   ipl_prio_enc #(.N(SW_N), .IW(SW_IW)) i_sw_enc (
      .req(sw_req_q[SW_LO +: SW_N]), .idx(sw_idx), .any(sw_any)
   );
   ipl_prio_enc #(.N(EXT_N), .IW(EXT_IW)) i_ext_enc (
      .req(ext_irq), .idx(ext_idx), .any(ext_any)
   );

   logic [LVL_W-1:0] sw_lvl, ext_lvl, win_lvl;
   always_comb begin
      sw_lvl  = sw_any ? LVL_W'(sw_idx) + LVL_W'(1) : '0;
      ext_lvl = LVL_W'(EXT_BASE) + LVL_W'(ext_idx);
      win_lvl = ext_any ? ext_lvl : sw_lvl;
   end

   // summary: software bits in place, external line j at EXT_BASE+j
   logic [DATA_W-1:0] ext_place;
   for (genvar b = 0; b < DATA_W; b++) begin : g_place
      if (b >= EXT_BASE && b <= EXT_TOP) begin : g_ext
         assign ext_place[b] = ext_irq[b - EXT_BASE];
      end else begin : g_zero
         assign ext_place[b] = 1'b0;
      end
   end

   logic [DATA_W-1:0] sum_now;
   logic              hit, fire;
   assign sum_now = sw_req_q | ext_place;
   assign hit     = (win_lvl != '0) && (win_lvl > ipl_q);
   assign fire    = arm && hit && !take;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take      <= 1'b0;
         summary_q <= '0;
         intid_q   <= '0;
      end else begin
         take <= fire;
         if (fire) begin
            summary_q <= sum_now;
            intid_q   <= win_lvl;
         end
      end
   end
endmodule

// File: rtl/ipl_arb_chk.sv
module ipl_arb_chk
   import ipl_arb_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SW_LO  = 4,
   parameter int SW_N   = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              arm,
   input logic              take,
   input logic [DATA_W-1:0] sw_req_q,
   input logic [LVL_W-1:0]  ipl_q,
   input logic [DATA_W-1:0] summary_q,
   input logic [LVL_W-1:0]  intid_q
);
   localparam logic [DATA_W-1:0] OUTSIDE = ~DATA_W'(field_mask(SW_LO, SW_N));

   a_r2_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req_q & OUTSIDE) == '0);

   a_r5_above_ipl: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (intid_q != '0) && (intid_q > $past(ipl_q)));

   a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !take);

   a_r8_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !take |-> $stable(summary_q) && $stable(intid_q));

   a_r9_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> $past(arm));
endmodule

bind ipl_arb ipl_arb_chk #(.DATA_W(DATA_W), .SW_LO(SW_LO), .SW_N(SW_N)) i_chk (
   .clk(clk), .rst_n(rst_n), .arm(arm), .take(take), .sw_req_q(sw_req_q),
   .ipl_q(ipl_q), .summary_q(summary_q), .intid_q(intid_q)
);

// File: tb/test_ipl_arb.sv
`timescale 1ns/1ps
module test_ipl_arb;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sw_wr = 1'b0;
   logic [DW-1:0] sw_wdata = '0;
   logic          ipl_wr = 1'b0;
   logic [4:0]    ipl_wdata = '0;
   logic [7:0]    ext_irq = '0;
   logic          arm = 1'b0;
   logic          take;
   logic [DW-1:0] sw_req_q, summary_q;
   logic [4:0]    ipl_q, intid_q;

   ipl_arb i_ipl_arb (
      .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
      .ipl_wr(ipl_wr), .ipl_wdata(ipl_wdata), .ext_irq(ext_irq), .arm(arm),
      .take(take), .sw_req_q(sw_req_q), .ipl_q(ipl_q),
      .summary_q(summary_q), .intid_q(intid_q)
   );

   always #4 clk = ~clk;   // 125 MHz

   typedef enum int {K_TAKE, K_SUM, K_ID, K_SWQ, K_IPL} kind_t;
   typedef struct {
      string         req;
      kind_t         kind;
      logic [DW-1:0] exp;
   } item_t;

   item_t q[$];
   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 0;

   logic [DW-1:0] m_sum = '0;
   logic [4:0]    m_id  = '0;

   // reference model from the requirements
   function automatic logic [4:0] win_of(logic [DW-1:0] sw, logic [7:0] ext);
      logic [4:0] l;
      l = 5'd0;
      for (int i = 4; i <= 18; i++) if (sw[i]) l = 5'(i - 3);
      for (int j = 0; j < 8; j++) if (ext[j]) l = 5'(20 + j);
      return l;
   endfunction

   function automatic logic [DW-1:0] act_of(kind_t k);
      case (k)
         K_TAKE:  return DW'(take);
         K_SUM:   return summary_q;
         K_ID:    return DW'(intid_q);
         K_SWQ:   return sw_req_q;
         default: return DW'(ipl_q);
      endcase
   endfunction

   // monitor: pops expected items and compares them with the ports
   always @(negedge clk) begin
      #2;
      while (q.size() > 0) begin
         item_t it;
         logic [DW-1:0] a;
         it = q.pop_front();
         a  = act_of(it.kind);
         n_chk++;
         if (a !== it.exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", it.req, it.kind.name(), a, it.exp);
         end
      end
   end

   task automatic push(string r, kind_t k, logic [DW-1:0] e);
      item_t it;
      it.req = r; it.kind = k; it.exp = e;
      q.push_back(it);
   endtask

   // driver: load registers, arm, then expect capture and pulse end
   task automatic scenario(string r, logic [DW-1:0] sw, logic [7:0] ext,
                           logic [4:0] ipl, logic a);
      logic [DW-1:0] swm;
      logic [4:0]    w;
      logic          tk;
      swm = sw & 32'h0007_fff0;
      w   = win_of(swm, ext);
      tk  = a && (w != 0) && (w > ipl);
      @(negedge clk);
      sw_wr = 1'b1; sw_wdata = sw; ipl_wr = 1'b1; ipl_wdata = ipl;
      ext_irq = ext; arm = 1'b0;
      @(negedge clk);
      sw_wr = 1'b0; ipl_wr = 1'b0; arm = a;
      #1;
      push({r, " R2 readback"}, K_SWQ, swm);
      push({r, " R10 ipl"}, K_IPL, DW'(ipl));
      push({r, " R6 no early take"}, K_TAKE, '0);
      @(negedge clk);
      #1;
      if (tk) begin
         m_sum = swm | (DW'(ext) << 20);
         m_id  = w;
      end
      push({r, " R5/R9 take"}, K_TAKE, DW'(tk));
      push({r, " R7/R8 summary"}, K_SUM, m_sum);
      push({r, " R3/R4 intid"}, K_ID, DW'(m_id));
      @(negedge clk);
      #1;
      push({r, " R6 pulse ends"}, K_TAKE, '0);
      push({r, " R8 summary held"}, K_SUM, m_sum);
      push({r, " R8 intid held"}, K_ID, DW'(m_id));
      arm = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      push("R1 reset", K_TAKE, '0);
      push("R1 reset", K_SUM, '0);
      push("R1 reset", K_ID, '0);
      push("R1 reset", K_SWQ, '0);
      push("R1 reset", K_IPL, '0);
      @(negedge clk);
      scenario("R2 full write", 32'hFFFF_FFFF, 8'h00, 5'd0, 1'b1);     // level 15
      scenario("R3 lowest sw", 32'h0000_0010, 8'h00, 5'd0, 1'b1);      // level 1
      scenario("R3 top sw", 32'h0004_0020, 8'h00, 5'd14, 1'b1);        // 15 > 14
      scenario("R5 equal sw", 32'h0004_0000, 8'h00, 5'd15, 1'b1);      // no take
      scenario("R2 outside bits", 32'hFFF8_000F, 8'h00, 5'd0, 1'b1);   // nothing
      scenario("R4 ext over sw", 32'h0004_0000, 8'h01, 5'd19, 1'b1);   // 20
      scenario("R4 highest ext", 32'h0000_0000, 8'h81, 5'd26, 1'b1);   // 27
      scenario("R5 equal ext", 32'h0000_0000, 8'h80, 5'd27, 1'b1);     // no take
      scenario("R9 disarmed", 32'h0000_0100, 8'h04, 5'd0, 1'b0);       // no take
      scenario("R4 mid ext", 32'h0000_0100, 8'h14, 5'd3, 1'b1);        // 24
      scenario("R5 below ipl", 32'h0000_0200, 8'h00, 5'd31, 1'b1);     // no take
      @(negedge clk);
      #3;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule